// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Unit

This block keeps the status flags and produces the interrupt requests of a CAN controller. Event strobes from the rest of the controller set the flags: a transmit buffer has become empty, a frame finished without error and moved into the receive foreground buffer, a queued frame moved into the foreground buffer, the receive FIFO overflowed, and bus activity was seen while the controller was asleep. The block also watches the transmit and receive error counters. It sorts each counter into a severity range and flags a status-change event whenever a range differs from its value one cycle earlier.

Software reaches the block through a small register port. A write happens on the cycle that `reg_we_i` is high. Reads are combinational from `reg_addr_i`. Writing a 1 to a flag bit clears that flag, and writing a 0 leaves it alone. Each interrupt source has its own enable bit. Four separate request lines (transmit, receive, wake-up and error) stay high for as long as an enabled flag is set. The block has no streaming data path, so no pin uses valid/ready and nothing at its edge can apply back-pressure. Every pin is a plain level or a one-cycle strobe.

Top module: `can_irq_flag_unit`

## Requirements
- R1: After synchronous reset, the three transmit-empty flags (address 2, bits 2:0) read 1. Every other flag, every enable, the wake-up arm bit (address 4, bit 0) and both status fields read 0, and all four interrupt outputs are low.
- R2: A pulse on `tx_empty_set_i[k]` sets transmit-empty flag k one clock later. Writing 1 to bit k of address 2 clears that flag.
- R3: `tx_irq_o` is high exactly when some transmit-empty flag k is set while its enable (address 3, bit k) is set.
- R4: A pulse on `rx_eof_ok_i` sets the receive-full flag (address 0, bit 0). Writing 1 to that bit clears it. `rx_irq_o` equals that flag ANDed with its enable (address 1, bit 0).
- R5: After the receive-full flag has been cleared, a pulse on `rx_fg_next_i` (the next queued frame has reached the foreground buffer) sets it again.
- R6: The wake-up flag (address 0, bit 3) sets only when `sleep_i`, `bus_act_i` and the arm bit (address 4, bit 0) are all high in the same cycle. `wake_irq_o` equals that flag ANDed with its enable (address 1, bit 3).
- R7: The transmit status field (address 0, bits 7:6) encodes the transmit counter as follows: 0 for a count below 96, 1 for 96 to 127, 2 for 128 to 255, and 3 for 256 or more.
- R8: The receive status field (address 0, bits 5:4) uses the same codes and limits, except that 128 or more gives 2. It never reads 3.
- R9: The status-change flag (address 0, bit 2) sets one clock after either encoded range differs from its value in the cycle before. A counter that stays inside its range sets no new event.
- R10: A pulse on `rx_overrun_i` sets the overrun flag (address 0, bit 1). `err_irq_o` is high when the overrun flag is set with its enable (address 1, bit 1) set, or when the status-change flag is set with its enable (address 1, bit 2) set.
- R11: When a set strobe and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R12: Writing 0 to a flag bit has no effect. An interrupt output stays high for as long as its enabled flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| tx_empty_set_i | input | 3 | Per-buffer strobe: transmit buffer became empty |
| rx_eof_ok_i | input | 1 | Strobe: frame done without error and moved to foreground |
| rx_fg_next_i | input | 1 | Strobe: next queued frame moved to foreground |
| rx_overrun_i | input | 1 | Strobe: receive FIFO overrun |
| sleep_i | input | 1 | Controller is in internal sleep mode |
| bus_act_i | input | 1 | Bus activity seen |
| tx_err_cnt_i | input | 9 | Transmit error counter |
| rx_err_cnt_i | input | 9 | Receive error counter |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |
| wake_irq_o | output | 1 | Wake-up interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The assertions check several rules on every cycle. A set strobe always leaves its flag set, a lone clear empties the flag, and a flag that is neither set nor cleared holds its value. Each status-change event is followed by a new range value, the receive range never reaches bus-off, and a request line is never high without a flag behind it. Only the bench's scenarios can show the range codes at each threshold, that the receive flag sets again for a queued frame, that the wake-up flag needs all three of its conditions, and how the enables gate each request line.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  typedef enum logic [1:0] {
    RNG_OK   = 2'd0,
    RNG_WARN = 2'd1,
    RNG_ERR  = 2'd2,
    RNG_OFF  = 2'd3
  } err_range_e;

  localparam int REG_ADDR_W = 3;
  localparam int REG_DATA_W = 8;

  localparam logic [REG_ADDR_W-1:0] A_EVT_FLAGS = 3'd0;
  localparam logic [REG_ADDR_W-1:0] A_EVT_IE    = 3'd1;
  localparam logic [REG_ADDR_W-1:0] A_TX_FLAGS  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] A_TX_IE     = 3'd3;
  localparam logic [REG_ADDR_W-1:0] A_CTRL      = 3'd4;

  localparam int EV_RXF  = 0;
  localparam int EV_OVR  = 1;
  localparam int EV_CHG  = 2;
  localparam int EV_WAKE = 3;
  localparam int NUM_EV  = 4;
endpackage

// File: rtl/cif_w1c_flag.sv
module cif_w1c_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      flag_q <= RST_VAL;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    set_i |=> flag_o);
  p_clear_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !set_i) |=> !flag_o);
  p_hold_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/cif_range_track.sv
module cif_range_track
  import can_irq_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter bit HAS_OFF  = 1'b1,
  parameter int WARN_LIM = 96,
  parameter int ERR_LIM  = 128,
  parameter int OFF_LIM  = 256
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] cnt_i,
  output err_range_e       range_o,
  output logic             change_o
);
  err_range_e enc;
  err_range_e range_q;

  always_comb begin
    if (int'(cnt_i) < WARN_LIM)                 enc = RNG_OK;
    else if (int'(cnt_i) < ERR_LIM)             enc = RNG_WARN;
    else if (HAS_OFF && int'(cnt_i) >= OFF_LIM) enc = RNG_OFF;
    else                                        enc = RNG_ERR;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) range_q <= RNG_OK;
    else       range_q <= enc;
  end

  assign range_o  = range_q;
  assign change_o = (enc != range_q);

  p_change_moves_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    change_o |=> (range_o != $past(range_o)));
  p_steady_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !change_o |=> $stable(range_o));

  if (!HAS_OFF) begin : g_no_off
    p_no_busoff_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      range_o != RNG_OFF);
  end
endmodule

// File: rtl/cif_irq_merge.sv
module cif_irq_merge #(
  parameter int NUM_TX = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NUM_TX-1:0] tx_flag_i,
  input  logic [NUM_TX-1:0] tx_ie_i,
  input  logic              rxf_i,
  input  logic              rxf_ie_i,
  input  logic              wake_i,
  input  logic              wake_ie_i,
  input  logic              ovr_i,
  input  logic              ovr_ie_i,
  input  logic              chg_i,
  input  logic              chg_ie_i,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              wake_irq_o,
  output logic              err_irq_o
);
  logic [NUM_TX-1:0] tx_hit;

  for (genvar k = 0; k < NUM_TX; k++) begin : g_tx
    assign tx_hit[k] = tx_flag_i[k] & tx_ie_i[k];
  end

  assign tx_irq_o   = |tx_hit;
  assign rx_irq_o   = rxf_i & rxf_ie_i;
  assign wake_irq_o = wake_i & wake_ie_i;
  assign err_irq_o  = (ovr_i & ovr_ie_i) | (chg_i & chg_ie_i);

  p_tx_src_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_irq_o |-> (tx_flag_i != '0));
  p_err_src_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    err_irq_o |-> (ovr_i || chg_i));
  p_rx_src_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_irq_o |-> rxf_i);
endmodule

// File: rtl/can_irq_flag_unit.sv
module can_irq_flag_unit
  import can_irq_pkg::*;
#(
  parameter int NUM_TX   = 3,
  parameter int CNT_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int ERR_LIM  = 128,
  parameter int OFF_LIM  = 256
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [REG_DATA_W-1:0] reg_wdata_i,
  output logic [REG_DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_TX-1:0]     tx_empty_set_i,
  input  logic                  rx_eof_ok_i,
  input  logic                  rx_fg_next_i,
  input  logic                  rx_overrun_i,
  input  logic                  sleep_i,
  input  logic                  bus_act_i,
  input  logic [CNT_W-1:0]      tx_err_cnt_i,
  input  logic [CNT_W-1:0]      rx_err_cnt_i,
  output logic                  tx_irq_o,
  output logic                  rx_irq_o,
  output logic                  wake_irq_o,
  output logic                  err_irq_o
);
  localparam int PAD_EV = REG_DATA_W - NUM_EV - 4;
  localparam int PAD_TX = REG_DATA_W - NUM_TX;

  logic                  wr_ev, wr_ev_ie, wr_tx, wr_tx_ie, wr_ctrl;
  logic [NUM_EV-1:0]     ev_set, ev_clr, ev_flag;
  logic [NUM_EV-1:0]     ev_ie_q;
  logic [NUM_TX-1:0]     tx_clr, tx_flag, tx_ie_q;
  logic                  wake_arm_q;
  err_range_e            tx_rng, rx_rng;
  logic                  tx_chg, rx_chg;
  logic                  unused_wdata;

  assign wr_ev    = reg_we_i && (reg_addr_i == A_EVT_FLAGS);
  assign wr_ev_ie = reg_we_i && (reg_addr_i == A_EVT_IE);
  assign wr_tx    = reg_we_i && (reg_addr_i == A_TX_FLAGS);
  assign wr_tx_ie = reg_we_i && (reg_addr_i == A_TX_IE);
  assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
  assign unused_wdata = ^reg_wdata_i;

  // Enables and control
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ev_ie_q    <= '0;
      tx_ie_q    <= '0;
      wake_arm_q <= 1'b0;
    end else begin
      if (wr_ev_ie) ev_ie_q    <= reg_wdata_i[NUM_EV-1:0];
      if (wr_tx_ie) tx_ie_q    <= reg_wdata_i[NUM_TX-1:0];
      if (wr_ctrl)  wake_arm_q <= reg_wdata_i[0];
    end
  end

  // Error-range trackers
  cif_range_track #(
    .CNT_W(CNT_W), .HAS_OFF(1'b1),
    .WARN_LIM(WARN_LIM), .ERR_LIM(ERR_LIM), .OFF_LIM(OFF_LIM)
  ) i_tx_rng (
    .clk_i(clk_i), .rst_i(rst_i), .cnt_i(tx_err_cnt_i),
    .range_o(tx_rng), .change_o(tx_chg)
  );

  cif_range_track #(
    .CNT_W(CNT_W), .HAS_OFF(1'b0),
    .WARN_LIM(WARN_LIM), .ERR_LIM(ERR_LIM), .OFF_LIM(OFF_LIM)
  ) i_rx_rng (
    .clk_i(clk_i), .rst_i(rst_i), .cnt_i(rx_err_cnt_i),
    .range_o(rx_rng), .change_o(rx_chg)
  );

  // Event flag set sources
  always_comb begin
    ev_set          = '0;
    ev_set[EV_RXF]  = rx_eof_ok_i | rx_fg_next_i;
    ev_set[EV_OVR]  = rx_overrun_i;
    ev_set[EV_CHG]  = tx_chg | rx_chg;
    ev_set[EV_WAKE] = sleep_i & bus_act_i & wake_arm_q;
  end

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    assign ev_clr[e] = wr_ev & reg_wdata_i[e];
    cif_w1c_flag #(.RST_VAL(1'b0)) i_flag (
      .clk_i(clk_i), .rst_i(rst_i),
      .set_i(ev_set[e]), .clr_i(ev_clr[e]), .flag_o(ev_flag[e])
    );
  end

  for (genvar k = 0; k < NUM_TX; k++) begin : g_tx
    assign tx_clr[k] = wr_tx & reg_wdata_i[k];
    cif_w1c_flag #(.RST_VAL(1'b1)) i_flag (
      .clk_i(clk_i), .rst_i(rst_i),
      .set_i(tx_empty_set_i[k]), .clr_i(tx_clr[k]), .flag_o(tx_flag[k])
    );
  end

  // Read mux
  always_comb begin
    case (reg_addr_i)
      A_EVT_FLAGS: reg_rdata_o = {tx_rng, rx_rng, {PAD_EV{1'b0}}, ev_flag};
      A_EVT_IE:    reg_rdata_o = {{(REG_DATA_W-NUM_EV){1'b0}}, ev_ie_q};
      A_TX_FLAGS:  reg_rdata_o = {{PAD_TX{1'b0}}, tx_flag};
      A_TX_IE:     reg_rdata_o = {{PAD_TX{1'b0}}, tx_ie_q};
      A_CTRL:      reg_rdata_o = {{(REG_DATA_W-1){1'b0}}, wake_arm_q};
      default:     reg_rdata_o = '0;
    endcase
  end

  cif_irq_merge #(.NUM_TX(NUM_TX)) i_merge (
    .clk_i(clk_i), .rst_i(rst_i),
    .tx_flag_i(tx_flag), .tx_ie_i(tx_ie_q),
    .rxf_i(ev_flag[EV_RXF]),   .rxf_ie_i(ev_ie_q[EV_RXF]),
    .wake_i(ev_flag[EV_WAKE]), .wake_ie_i(ev_ie_q[EV_WAKE]),
    .ovr_i(ev_flag[EV_OVR]),   .ovr_ie_i(ev_ie_q[EV_OVR]),
    .chg_i(ev_flag[EV_CHG]),   .chg_ie_i(ev_ie_q[EV_CHG]),
    .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o),
    .wake_irq_o(wake_irq_o), .err_irq_o(err_irq_o)
  );

  p_wake_gate_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !(sleep_i && bus_act_i && wake_arm_q) |=> !$rose(ev_flag[EV_WAKE]));
  p_rxf_source_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !(rx_eof_ok_i || rx_fg_next_i) |=> !$rose(ev_flag[EV_RXF]));
endmodule

// File: tb/test_can_irq_flag_unit.sv
module test_can_irq_flag_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       we;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [2:0] tx_set;
  logic       eof_ok, fg_next, ovr, sleep, act;
  logic [8:0] tx_cnt, rx_cnt;
  logic       tx_irq, rx_irq, wake_irq, err_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  can_irq_flag_unit i_can_irq_flag_unit (
    .clk_i(clk), .rst_i(rst), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_empty_set_i(tx_set),
    .rx_eof_ok_i(eof_ok), .rx_fg_next_i(fg_next), .rx_overrun_i(ovr),
    .sleep_i(sleep), .bus_act_i(act), .tx_err_cnt_i(tx_cnt),
    .rx_err_cnt_i(rx_cnt), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq),
    .wake_irq_o(wake_irq), .err_irq_o(err_irq)
  );

  // {tx_cnt, rx_cnt, exp tx range, exp rx range}
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {9'd0,   9'd0,   2'd0, 2'd0},
    {9'd95,  9'd95,  2'd0, 2'd0},
    {9'd96,  9'd96,  2'd1, 2'd1},
    {9'd127, 9'd127, 2'd1, 2'd1},
    {9'd128, 9'd128, 2'd2, 2'd2},
    {9'd255, 9'd255, 2'd2, 2'd2},
    {9'd256, 9'd300, 2'd3, 2'd2},
    {9'd511, 9'd511, 2'd3, 2'd2},
    {9'd511, 9'd0,   2'd3, 2'd0},
    {9'd10,  9'd100, 2'd0, 2'd1}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [1:0] ptx, prx;
    rst = 1'b1; we = 0; addr = 0; wdata = 0; tx_set = 0;
    eof_ok = 0; fg_next = 0; ovr = 0; sleep = 0; act = 0;
    tx_cnt = 0; rx_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();

    // R1 reset state
    rd(3'd0, d); chk("R1 event flags", d, 0);
    rd(3'd1, d); chk("R1 event enables", d, 0);
    rd(3'd2, d); chk("R1 tx flags", d, 7);
    rd(3'd3, d); chk("R1 tx enables", d, 0);
    rd(3'd4, d); chk("R1 arm", d, 0);
    chk("R1 irqs", {tx_irq, rx_irq, wake_irq, err_irq}, 0);

    // R7 R8 R9 range table
    ptx = 0; prx = 0;
    for (int i = 0; i < NV; i++) begin
      tx_cnt = VEC[i][21:13];
      rx_cnt = VEC[i][12:4];
      idle();
      rd(3'd0, d);
      chk("R7 tx range", d[7:6], VEC[i][3:2]);
      chk("R8 rx range", d[5:4], VEC[i][1:0]);
      chk("R9 status change", d[2],
          int'((VEC[i][3:2] != ptx) || (VEC[i][1:0] != prx)));
      ptx = VEC[i][3:2]; prx = VEC[i][1:0];
      wr(3'd0, 8'h04);
      rd(3'd0, d); chk("R9 steady no event", d[2], 0);
    end

    // R2 R12 transmit flags
    wr(3'd2, 8'h05);
    rd(3'd2, d); chk("R2 w1c clear", d, 2);
    wr(3'd2, 8'h00);
    rd(3'd2, d); chk("R12 write zero", d, 2);
    tx_set = 3'b001; idle(); tx_set = 0;
    rd(3'd2, d); chk("R2 set strobe", d, 3);
    // R3
    chk("R3 no enable", tx_irq, 0);
    wr(3'd3, 8'h04);
    chk("R3 enable on empty-less buffer", tx_irq, 0);
    wr(3'd3, 8'h01);
    chk("R3 enabled flag", tx_irq, 1);
    idle(); idle();
    chk("R12 irq persists", tx_irq, 1);
    wr(3'd2, 8'h01);
    chk("R3 cleared", tx_irq, 0);

    // R4 R5 R11 receive
    eof_ok = 1; idle(); eof_ok = 0;
    rd(3'd0, d); chk("R4 rx full set", d[0], 1);
    chk("R4 rx irq gated", rx_irq, 0);
    wr(3'd1, 8'h01);
    chk("R4 rx irq", rx_irq, 1);
    wr(3'd0, 8'h01);
    rd(3'd0, d); chk("R4 rx cleared", d[0], 0);
    chk("R4 rx irq low", rx_irq, 0);
    fg_next = 1; idle(); fg_next = 0;
    rd(3'd0, d); chk("R5 rx reasserts", d[0], 1);
    wr(3'd0, 8'h01);
    eof_ok = 1; wr(3'd0, 8'h01); eof_ok = 0;
    rd(3'd0, d); chk("R11 set wins", d[0], 1);
    tx_set = 3'b100; wr(3'd2, 8'h04); tx_set = 0;
    rd(3'd2, d); chk("R11 tx set wins", d[2], 1);

    // R6 wake-up
    sleep = 1; act = 1; idle(); act = 0;
    rd(3'd0, d); chk("R6 unarmed", d[3], 0);
    wr(3'd4, 8'h01);
    sleep = 0; act = 1; idle(); act = 0;
    rd(3'd0, d); chk("R6 awake", d[3], 0);
    sleep = 1; idle();
    rd(3'd0, d); chk("R6 no activity", d[3], 0);
    act = 1; idle(); act = 0; sleep = 0;
    rd(3'd0, d); chk("R6 wake set", d[3], 1);
    chk("R6 wake irq gated", wake_irq, 0);
    wr(3'd1, 8'h08);
    chk("R6 wake irq", wake_irq, 1);

    // R10 overrun and status-change error irq
    ovr = 1; idle(); ovr = 0;
    rd(3'd0, d); chk("R10 overrun flag", d[1], 1);
    chk("R10 err gated", err_irq, 0);
    wr(3'd1, 8'h02);
    chk("R10 err on overrun", err_irq, 1);
    wr(3'd0, 8'h02);
    chk("R10 err cleared", err_irq, 0);
    tx_cnt = 9'd200; idle();
    chk("R10 change gated", err_irq, 0);
    wr(3'd1, 8'h04);
    chk("R10 err on change", err_irq, 1);
    wr(3'd0, 8'h04);
    chk("R10 change cleared", err_irq, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule